// File: doc/BRIEF.md
# Word ECC Read-Modify-Write Engine

This block sits between a byte-addressed requester and a storage array that holds 32-bit words. Each word is stored together with 6 check bits of a single-error-correcting Hamming code, so every stored entry is 38 bits wide. On a read, the block fetches the entry and recomputes the code. If one bit is wrong, it repairs it and returns the 32 data bits with a flag saying that a repair took place.

Writes carry four byte enables. When all four are set, the block encodes the new word and writes it straight to storage in the cycle the request is accepted. When fewer are set, the block reads the aligned word and corrects it. It then replaces the enabled byte lanes, recomputes the check bits and writes all 38 bits back. This also scrubs any single-bit error that was sitting in the old word. The storage port has a fixed read latency of `RD_LAT` cycles. While a read or a read-modify-write is in progress, `req_ready` is low and no new request is taken.

Top module: `word_ecc_rmw`

## Requirements
- R1: Every stored entry is `{chk[5:0], data[31:0]}`. Codeword positions 1..38 hold check bit k at position 2^k. Data bit 0 sits at position 3, and the remaining data bits fill the other non-power-of-two positions in ascending order. Check bit k is the XOR of the data bits whose position has bit k set.
- R2: A read accepted in cycle t drives `mem_re` in cycle t. It raises `rsp_valid` for exactly one cycle, t+RD_LAT, which is the cycle `mem_rdata` arrives.
- R3: A read whose stored entry has exactly one flipped data bit returns the original data with `rsp_corrected` = 1.
- R4: A read whose stored entry has exactly one flipped check bit returns the data bits unchanged with `rsp_corrected` = 1.
- R5: A read of an error-free entry returns its data with `rsp_corrected` = 0.
- R6: A write with `req_be` = 4'b1111 raises `mem_we` without `mem_re` in its accept cycle. It stores the encoded word, and `req_ready` stays high in the next cycle.
- R7: A write with any other `req_be` reads the aligned word and writes it back in cycle t+RD_LAT. In the written word, lane j (bits 8j+7:8j) takes the new byte when `req_be[j]` = 1 and keeps the old byte when it is 0.
- R8: During a partial write, a single-bit error in the old word is corrected before merging, so the written-back entry is error-free. This holds even when `req_be` = 0.
- R9: After a read or a partial write is accepted in cycle t, `req_ready` is low from t+1 through t+RD_LAT and high again at t+RD_LAT+1.
- R10: The two low bits of `req_addr` are ignored; the storage word is `req_addr[ADDR_W-1:2]`.
- R11: While reset is asserted, and after its release with no request, `req_ready` = 1 and `rsp_valid`, `mem_re` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_be | input | 4 | Byte-lane enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Corrected read data |
| rsp_corrected | output | 1 | A single-bit error was repaired |
| mem_re | output | 1 | Storage read strobe |
| mem_we | output | 1 | Storage write strobe |
| mem_addr | output | ADDR_W-2 | Storage word address |
| mem_wdata | output | 38 | Codeword to store |
| mem_rdata | input | 38 | Codeword read, RD_LAT cycles after mem_re |

## Verification
The bench flips one bit at each end of the data field and one bit at each end of the check field, and also reads clean words, including all-ones. A syndrome decoded to the wrong position would corrupt a neighbouring bit, and a missing repair flag would hide the error. Partial writes are run with mixed enables, a single high lane and no lane at all. A merge that used the uncorrected old word would write a latent error back with fresh check bits, and the bench's stored-word comparison would catch it as silent corruption. Ready timing around the read latency and the unused address bits are also probed: an off-by-one in the latency count would drop or shift the response cycle.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } rmw_state_e;

  // Hamming position (1-based) of data bit idx: skips powers of two.
  function automatic logic [CHK_W-1:0] data_pos(int idx);
    int d;
    logic [CHK_W-1:0] r;
    d = 0;
    r = '0;
    for (int p = 1; p <= CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d == idx) r = CHK_W'(p);
        d++;
      end
    end
    return r;
  endfunction

  // Data bits covered by check bit k.
  function automatic logic [DATA_W-1:0] chk_mask(int k);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  p;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      p    = data_pos(i);
      m[i] = p[k];
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  for (genvar k = 0; k < CHK_W; k++) begin : g_chk
    localparam logic [DATA_W-1:0] COVER = chk_mask(k);
    assign chk_o[k] = ^(data_i & COVER);
  end

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
  import ecc_pkg::*;
(
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              fixed_o
);

  logic [CHK_W-1:0]  recalc;
  logic [CHK_W-1:0]  syndrome;
  logic [DATA_W-1:0] flip;

  ecc_enc u_recalc (
    .data_i (cw_i[DATA_W-1:0]),
    .chk_o  (recalc)
  );

  assign syndrome = recalc ^ cw_i[CW_W-1:DATA_W];

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam logic [CHK_W-1:0] POS = data_pos(i);
    assign flip[i] = (syndrome == POS);
  end

  assign data_o  = cw_i[DATA_W-1:0] ^ flip;
  assign fixed_o = |syndrome;

endmodule

// File: rtl/ecc_rmw_ctrl.sv
module ecc_rmw_ctrl
  import ecc_pkg::*;
#(
  parameter int WADDR_W = 6,
  parameter int RD_LAT  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [LANES-1:0]   req_be,
  input  logic [WADDR_W-1:0] req_waddr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               mem_re,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic               sel_merge,
  output logic               rsp_valid,
  output logic [LANES-1:0]   hold_be,
  output logic [DATA_W-1:0]  hold_wdata
);

  localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_LAT - 1);

  rmw_state_e         st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               rmw_q, rmw_d;
  logic               cap_en;
  logic [WADDR_W-1:0] addr_q;
  logic               full_word;
  logic               last_beat;

  assign full_word = &req_be;
  assign last_beat = (st_q == ST_WAIT) && (cnt_q == CNT_LAST);
  assign req_ready = (st_q == ST_IDLE);

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    rmw_d     = rmw_q;
    cap_en    = 1'b0;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = addr_q;
    sel_merge = 1'b0;
    rsp_valid = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        mem_addr = req_waddr;
        if (req_valid) begin
          if (req_we && full_word) begin
            mem_we = 1'b1;
          end else begin
            mem_re = 1'b1;
            cap_en = 1'b1;
            rmw_d  = req_we;
            cnt_d  = '0;
            st_d   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (last_beat) begin
          st_d = ST_IDLE;
          if (rmw_q) begin
            mem_we    = 1'b1;
            sel_merge = 1'b1;
          end else begin
            rsp_valid = 1'b1;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rmw_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      rmw_q <= rmw_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q     <= req_waddr;
      hold_be    <= req_be;
      hold_wdata <= req_wdata;
    end
  end

  // R9
  stall_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_we && (&req_be))) |=> !req_ready);

  // R6
  full_write_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we && (&req_be)) |-> (mem_we && !mem_re));

  // R6
  full_write_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_we && (&req_be)) |=> req_ready);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R2
  rsp_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (!req_ready && !mem_we));

endmodule

// File: rtl/word_ecc_rmw.sv
module word_ecc_rmw
  import ecc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [LANES-1:0]    req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_corrected,
  output logic                mem_re,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [CW_W-1:0]     mem_wdata,
  input  logic [CW_W-1:0]     mem_rdata
);

  localparam int WADDR_W = ADDR_W - 2;

  logic [WADDR_W-1:0] req_waddr;
  logic [1:0]         unused_byte_off;
  logic               sel_merge;
  logic [LANES-1:0]   hold_be;
  logic [DATA_W-1:0]  hold_wdata;
  logic [DATA_W-1:0]  old_data;
  logic               old_fixed;
  logic [DATA_W-1:0]  merged;
  logic [DATA_W-1:0]  wr_data;
  logic [CHK_W-1:0]   wr_chk;

  assign req_waddr       = req_addr[ADDR_W-1:2];
  assign unused_byte_off = req_addr[1:0];

  ecc_rmw_ctrl #(
    .WADDR_W (WADDR_W),
    .RD_LAT  (RD_LAT)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_we     (req_we),
    .req_be     (req_be),
    .req_waddr  (req_waddr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .sel_merge  (sel_merge),
    .rsp_valid  (rsp_valid),
    .hold_be    (hold_be),
    .hold_wdata (hold_wdata)
  );

  ecc_dec u_dec (
    .cw_i    (mem_rdata),
    .data_o  (old_data),
    .fixed_o (old_fixed)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign merged[8*j +: 8] = hold_be[j] ? hold_wdata[8*j +: 8] : old_data[8*j +: 8];
  end

  assign wr_data = sel_merge ? merged : req_wdata;

  ecc_enc u_enc (
    .data_i (wr_data),
    .chk_o  (wr_chk)
  );

  assign mem_wdata     = {wr_chk, wr_data};
  assign rsp_rdata     = old_data;
  assign rsp_corrected = rsp_valid & old_fixed;

  // R3
  single_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones(rsp_rdata ^ mem_rdata[DATA_W-1:0]) <= 1));

  // R5
  clean_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_corrected) |-> (rsp_rdata == mem_rdata[DATA_W-1:0]));

endmodule

// File: tb/word_ecc_rmw_bench.sv
`timescale 1ns/1ps
module word_ecc_rmw_bench;

  localparam int ADDR_W = 8;
  localparam int RD_LAT = 2;
  localparam int WORDS  = 1 << (ADDR_W - 2);
  localparam int NVEC   = 8;

  localparam logic [31:0] V_DATA [NVEC] = '{32'h0123_4567, 32'hDEAD_BEEF, 32'h8000_0001,
                                           32'h5A5A_A5A5, 32'hCAFE_F00D, 32'h0000_0000,
                                           32'hFFFF_FFFF, 32'h1357_9BDF};
  localparam int V_FLIP [NVEC] = '{-1, 0, 31, 17, 32, 37, -1, 5};

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_we;
  logic [ADDR_W-1:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_corrected;
  logic [31:0] rsp_rdata;
  logic        mem_re, mem_we;
  logic [ADDR_W-3:0] mem_addr;
  logic [37:0] mem_wdata, mem_rdata;

  logic [37:0] bmem [WORDS];
  logic [37:0] pipe [RD_LAT];
  logic        poke_en;
  logic [ADDR_W-3:0] poke_addr;
  logic [37:0] poke_data;
  int n_re, n_we;
  int checks, fails;
  bit done;

  word_ecc_rmw #(.ADDR_W(ADDR_W), .RD_LAT(RD_LAT)) u_word_ecc_rmw (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_corrected(rsp_corrected),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // storage model with fixed read latency
  always @(posedge clk) begin
    if (poke_en) bmem[poke_addr] <= poke_data;
    else if (mem_we) bmem[mem_addr] <= mem_wdata;
    pipe[0] <= mem_re ? bmem[mem_addr] : 38'h0;
    for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign mem_rdata = pipe[RD_LAT-1];

  always @(posedge clk) begin
    if (rst_n) begin
      if (mem_re) n_re <= n_re + 1;
      if (mem_we) n_we <= n_we + 1;
    end
  end

  // R1 encoding: XOR of the positions of set data bits
  function automatic logic [37:0] b_enc(logic [31:0] d);
    logic [5:0] s;
    int di;
    s  = '0;
    di = 0;
    for (int p = 1; p <= 38; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[di]) s = s ^ 6'(p);
        di++;
      end
    end
    return {s, d};
  endfunction

  function automatic logic [37:0] flip_bit(logic [37:0] cw, int b);
    logic [37:0] r;
    r = cw;
    if (b >= 0) r[b] = ~r[b];
    return r;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic poke(int w, logic [37:0] cw);
    @(negedge clk);
    poke_en = 1'b1; poke_addr = (ADDR_W-2)'(w); poke_data = cw;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic do_read(logic [ADDR_W-1:0] a, logic [31:0] exp_d, bit exp_c, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_be = 4'h0;
    #1;
    check(req_ready && mem_re && !mem_we, "R2 accept/mem_re", {req_ready, mem_re, mem_we}, 3'b110);
    @(negedge clk);
    req_valid = 1'b0;
    check(!rsp_valid && !req_ready, "R9 stall t+1", {rsp_valid, req_ready}, 2'b00);
    repeat (RD_LAT - 1) @(negedge clk);
    check(rsp_valid, "R2 rsp_valid at t+RD_LAT", rsp_valid, 1);
    check(rsp_rdata == exp_d, tag, rsp_rdata, exp_d);
    check(rsp_corrected == exp_c, {tag, " flag"}, rsp_corrected, exp_c);
    check(!req_ready, "R9 ready low at t+RD_LAT", req_ready, 0);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R9 ready back", {rsp_valid, req_ready}, 2'b01);
  endtask

  task automatic do_pwrite(logic [ADDR_W-1:0] a, logic [3:0] be, logic [31:0] d);
    int re0, we0;
    @(negedge clk);
    re0 = n_re; we0 = n_we;
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_be = be; req_wdata = d;
    #1;
    check(mem_re && !mem_we, "R7 old word read", {mem_re, mem_we}, 2'b10);
    @(negedge clk);
    req_valid = 1'b0; req_wdata = 32'h0; req_be = 4'h0;
    check(!req_ready, "R9 partial stall", req_ready, 0);
    repeat (RD_LAT) @(negedge clk);
    check(req_ready, "R9 partial ready back", req_ready, 1);
    check(n_re == re0 + 1 && n_we == we0 + 1, "R7 one read one write",
          {n_re - re0, n_we - we0}, {32'd1, 32'd1});
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    n_re = 0; n_we = 0;
    poke_en = 1'b0; poke_addr = '0; poke_data = '0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_be = '0; req_wdata = '0;
    rst_n = 1'b0;
    for (int i = 0; i < RD_LAT; i++) pipe[i] = '0;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_re && !mem_we, "R11 in reset",
          {req_ready, rsp_valid, mem_re, mem_we}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_re && !mem_we, "R11 after release",
          {req_ready, rsp_valid, mem_re, mem_we}, 4'b1000);

    // vector table: R3 data flips, R4 check flips, R5 clean words
    for (int k = 0; k < NVEC; k++) begin
      poke(k, flip_bit(b_enc(V_DATA[k]), V_FLIP[k]));
      do_read(ADDR_W'(k * 4), V_DATA[k], V_FLIP[k] >= 0,
              V_FLIP[k] < 0 ? "R5 clean read" : (V_FLIP[k] < 32 ? "R3 data-bit fix" : "R4 check-bit fix"));
    end

    // R6 full-word write, R1 stored format
    begin
      int re0, we0;
      @(negedge clk);
      re0 = n_re; we0 = n_we;
      req_valid = 1'b1; req_we = 1'b1; req_addr = 8'h40; req_be = 4'hF; req_wdata = 32'hA5C3_0F96;
      #1;
      check(mem_we && !mem_re && req_ready, "R6 direct write strobes",
            {mem_we, mem_re, req_ready}, 3'b101);
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready, "R6 no stall", req_ready, 1);
      check(n_re == re0 && n_we == we0 + 1, "R6 counts", {n_re - re0, n_we - we0}, {32'd0, 32'd1});
      check(bmem[16] == b_enc(32'hA5C3_0F96), "R1 stored codeword", bmem[16], b_enc(32'hA5C3_0F96));
    end

    // R7 merge with mixed lanes
    poke(20, b_enc(32'h1122_3344));
    do_pwrite(8'd80, 4'b0101, 32'hAABB_CCDD);
    check(bmem[20] == b_enc(32'h11BB_33DD), "R7 merged lanes", bmem[20], b_enc(32'h11BB_33DD));

    // R10 low address bits ignored
    do_read(8'd83, 32'h11BB_33DD, 1'b0, "R10 offset 3 read");

    // R8 latent data-bit error scrubbed by partial write
    poke(21, flip_bit(b_enc(32'h0F0F_0F0F), 9));
    do_pwrite(8'd84, 4'b1000, 32'h7700_0000);
    check(bmem[21] == b_enc(32'h770F_0F0F), "R8 scrub data bit", bmem[21], b_enc(32'h770F_0F0F));

    // R8 latent check-bit error, single low lane
    poke(22, flip_bit(b_enc(32'h2468_ACE0), 35));
    do_pwrite(8'd90, 4'b0001, 32'h0000_0099);
    check(bmem[22] == b_enc(32'h2468_AC99), "R8 scrub check bit", bmem[22], b_enc(32'h2468_AC99));

    // R8 no lanes enabled: pure scrub
    poke(23, flip_bit(b_enc(32'hF00D_1234), 2));
    do_pwrite(8'd92, 4'b0000, 32'hFFFF_FFFF);
    check(bmem[23] == b_enc(32'hF00D_1234), "R8 be=0 scrub", bmem[23], b_enc(32'hF00D_1234));
    do_read(8'd92, 32'hF00D_1234, 1'b0, "R5 read after scrub");

    summary();
  end

endmodule